// File: doc/BRIEF.md
# Subtract Execution Unit

This block carries out the two subtract instructions of an 8-bit accumulator processor. One form takes an 8-bit immediate value and subtracts the working register from it. The other form subtracts the working register from a byte held in data memory. The block decodes a 16-bit instruction word and builds a 12-bit data-memory address for the register form. It reads the operand, forms the 8-bit two's-complement difference and its five status flags, and writes the result to the working register or back to memory.

Every instruction takes one instruction cycle of four clock phases. A free-running phase counter sequences the work: decode, operand read, subtract, then write-back. The data memory is built into the block. It is organised as banks of 256 bytes. A port used only for observation can read any memory byte combinationally. Instruction fetch, the program counter and every other opcode are handled elsewhere. A word that is not one of the two subtracts changes nothing and raises a one-cycle strobe.

Top module: `sub_exec_unit`

## Requirements
- R1: A word whose upper byte is 08h is the immediate form. It writes (low byte − W) mod 256 to W and leaves data memory unchanged.
- R2: A word whose bits 15:10 are 010111 is the register form. Bit 9 is the destination bit, bit 8 is the bank-mode bit and bits 7:0 are the file offset f. The result is (mem[addr] − W) mod 256. It goes to W when the destination bit is 0, and to mem[addr] when it is 1. The location that is not written keeps its value.
- R3: When the bank-mode bit is 1, addr = {bank_sel_i, f}, whatever the values of ext_mode_i and index_ptr_i.
- R4: When the bank-mode bit is 0 and indexed mode does not apply, f from 00h to 5Fh maps to addr 000h–05Fh and f from 60h to FFh maps to F60h–FFFh. bank_sel_i is ignored.
- R5: When ext_mode_i = 1, the bank-mode bit = 0 and f ≤ 5Fh, addr = (index_ptr_i + f) mod 4096. Above 5Fh the mapping of R4 applies.
- R6: status_o[0] is the carry flag. It is 1 when the minuend is greater than or equal to the subtrahend (no borrow) and 0 when a borrow occurs.
- R7: status_o[2] is the zero flag (result = 0) and status_o[4] is the negative flag (result bit 7).
- R8: status_o[1] is the digit-carry flag. It is 1 when there is no borrow out of bit 3, that is when the minuend's low nibble ≥ the subtrahend's low nibble.
- R9: status_o[3] is the overflow flag. It is 1 when the signed difference lies outside −128..127.
- R10: phase_o counts 0,1,2,3 and repeats. The word on instr_i is taken at the rising edge where phase_o = 0. W, flags and memory all change at the fourth rising edge counted from that one, and not before it.
- R11: Any other word leaves W, the flags and memory unchanged. It raises unimpl_o for exactly one clock, starting at the fourth edge.
- R12: While rst_n is low, W, the flags, phase_o, unimpl_o and every memory byte go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word, taken while phase_o = 0 |
| bank_sel_i | input | 4 | Bank number for banked addressing |
| ext_mode_i | input | 1 | Enables indexed addressing for low offsets |
| index_ptr_i | input | 12 | Base pointer for indexed addressing |
| peek_addr_i | input | 12 | Observation read address |
| peek_data_o | output | 8 | Memory byte at peek_addr_i (combinational) |
| w_o | output | 8 | Working register |
| status_o | output | 5 | {N, OV, Z, DC, C} |
| phase_o | output | 2 | Current phase of the instruction cycle |
| unimpl_o | output | 1 | One-clock strobe for a word that is not a subtract |

## Verification
The bench presents a word while phase_o reads 0. It counts four rising edges and samples W, status, the peek port and unimpl_o at the falling edge that follows. At that point the write-back edge has passed and the next instruction cycle has not yet latched anything. A dedicated check samples W after only three edges to confirm that nothing moves early. A further falling edge confirms that the unimplemented strobe has dropped again. Memory contents are read through the peek port in that same settled window. The bench compares them against expected values it computes from its own arithmetic model and from its own address mapping.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_IMM  = 2'd1,
      OP_MEM  = 2'd2
   } sub_op_e;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic zero;
      logic dcy;
      logic cy;
   } sub_flags_t;

   localparam logic [7:0] IMM_UPPER = 8'h08;
   localparam logic [5:0] MEM_UPPER = 6'b010111;

endpackage

// File: rtl/sub_decode.sv
module sub_decode
   import sub_exec_pkg::*;
#(
   parameter int         BANK_BITS  = 4,
   parameter bit         INDEX_EN   = 1'b1,
   parameter logic [7:0] ACCESS_TOP = 8'h5F,
   localparam int        AW         = BANK_BITS + 8
) (
   input  logic [15:0]          instr_i,
   input  logic [BANK_BITS-1:0] bank_sel_i,
   input  logic                 ext_mode_i,
   input  logic [AW-1:0]        index_ptr_i,
   output sub_op_e              op_o,
   output logic                 to_mem_o,
   output logic [AW-1:0]        addr_o,
   output logic [7:0]           imm_o
);

   logic          dest_bit;
   logic          bank_mode;
   logic [7:0]    offs;
   logic          low_half;
   logic [AW-1:0] banked_addr;
   logic [AW-1:0] access_addr;
   logic          idx_hit;
   logic [AW-1:0] idx_addr;

   assign dest_bit  = instr_i[9];
   assign bank_mode = instr_i[8];
   assign offs      = instr_i[7:0];
   assign imm_o     = instr_i[7:0];
   assign low_half  = (offs <= ACCESS_TOP);

   always_comb begin
      if (instr_i[15:8] == IMM_UPPER)
         op_o = OP_IMM;
      else if (instr_i[15:10] == MEM_UPPER)
         op_o = OP_MEM;
      else
         op_o = OP_NONE;
   end

   assign banked_addr = {bank_sel_i, offs};
   assign access_addr = low_half ? {{BANK_BITS{1'b0}}, offs}
                                 : {{BANK_BITS{1'b1}}, offs};

   generate
      if (INDEX_EN) begin : g_index
         assign idx_hit  = ext_mode_i & ~bank_mode & low_half;
         assign idx_addr = index_ptr_i + {{BANK_BITS{1'b0}}, offs};
      end else begin : g_no_index
         logic unused_idx;
         assign unused_idx = ext_mode_i ^ (^index_ptr_i);
         assign idx_hit    = 1'b0;
         assign idx_addr   = '0;
      end
   endgenerate

   always_comb begin
      if (bank_mode)
         addr_o = banked_addr;
      else if (idx_hit)
         addr_o = idx_addr;
      else
         addr_o = access_addr;
   end

   assign to_mem_o = (op_o == OP_MEM) & dest_bit;

endmodule

// File: rtl/sub_alu.sv
module sub_alu
   import sub_exec_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] minuend_i,
   input  logic [DW-1:0] subtra_i,
   output logic [DW-1:0] diff_o,
   output sub_flags_t    flags_o
);

   localparam int NIB = 4;

   logic [DW:0]    wide;
   logic [NIB:0]   low_wide;
   logic           sign_m;
   logic           sign_s;

   generate
      if (DW < NIB + 1) begin : g_bad_width
         $error("sub_alu: DW must exceed the nibble width");
      end
   endgenerate

   assign wide     = {1'b0, minuend_i} - {1'b0, subtra_i};
   assign low_wide = {1'b0, minuend_i[NIB-1:0]} - {1'b0, subtra_i[NIB-1:0]};
   assign sign_m   = minuend_i[DW-1];
   assign sign_s   = subtra_i[DW-1];
   assign diff_o   = wide[DW-1:0];

   always_comb begin
      flags_o.cy   = ~wide[DW];
      flags_o.dcy  = ~low_wide[NIB];
      flags_o.zero = (wide[DW-1:0] == '0);
      flags_o.neg  = wide[DW-1];
      flags_o.ovf  = (sign_m ^ sign_s) & (sign_m ^ wide[DW-1]);
   end

   always_comb begin
      a_r6_zero_has_no_borrow: assert (!(flags_o.zero && !flags_o.cy))
         else $error("R6: zero result reported with a borrow");
      a_r9_ovf_needs_mixed_signs: assert (!flags_o.ovf || (sign_m != sign_s))
         else $error("R9: overflow with like-signed operands");
   end

endmodule

// File: rtl/sub_regfile.sv
module sub_regfile #(
   parameter int  BANK_BITS = 4,
   localparam int AW        = BANK_BITS + 8,
   localparam int BANKS     = 1 << BANK_BITS,
   localparam int BANK_SZ   = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_a_i,
   output logic [7:0]    rdata_a_o,
   input  logic [AW-1:0] raddr_b_i,
   output logic [7:0]    rdata_b_o
);

   logic [7:0] rd_a_bank [BANKS];
   logic [7:0] rd_b_bank [BANKS];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic [7:0] cells [BANK_SZ];
         logic       hit;

         assign hit = we_i && (waddr_i[AW-1:8] == BANK_BITS'(b));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < BANK_SZ; i++)
                  cells[i] <= '0;
            end else if (hit) begin
               cells[waddr_i[7:0]] <= wdata_i;
            end
         end

         assign rd_a_bank[b] = cells[raddr_a_i[7:0]];
         assign rd_b_bank[b] = cells[raddr_b_i[7:0]];
      end
   endgenerate

   assign rdata_a_o = rd_a_bank[raddr_a_i[AW-1:8]];
   assign rdata_b_o = rd_b_bank[raddr_b_i[AW-1:8]];

endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
   import sub_exec_pkg::*;
#(
   parameter int         BANK_BITS  = 4,
   parameter bit         INDEX_EN   = 1'b1,
   parameter logic [7:0] ACCESS_TOP = 8'h5F,
   localparam int        AW         = BANK_BITS + 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          instr_i,
   input  logic [BANK_BITS-1:0] bank_sel_i,
   input  logic                 ext_mode_i,
   input  logic [AW-1:0]        index_ptr_i,
   input  logic [AW-1:0]        peek_addr_i,
   output logic [7:0]           peek_data_o,
   output logic [7:0]           w_o,
   output logic [4:0]           status_o,
   output logic [1:0]           phase_o,
   output logic                 unimpl_o
);

   localparam logic [1:0] PH_DECODE = 2'd0;
   localparam logic [1:0] PH_READ   = 2'd1;
   localparam logic [1:0] PH_CALC   = 2'd2;
   localparam logic [1:0] PH_WRITE  = 2'd3;

   generate
      if (BANK_BITS < 1 || BANK_BITS > 8) begin : g_bad_banks
         $error("sub_exec_unit: BANK_BITS out of range");
      end
      if (ACCESS_TOP == 8'hFF) begin : g_bad_split
         $error("sub_exec_unit: access split leaves no upper region");
      end
   endgenerate

   sub_op_e       dec_op;
   logic          dec_to_mem;
   logic [AW-1:0] dec_addr;
   logic [7:0]    dec_imm;

   logic [1:0]    phase_q;
   sub_op_e       op_q;
   logic          to_mem_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    imm_q;
   logic [7:0]    min_q;
   logic [7:0]    sub_q;
   logic [7:0]    res_q;
   sub_flags_t    flg_q;
   logic [7:0]    w_q;
   sub_flags_t    stat_q;
   logic          unimpl_q;

   logic [7:0]    opnd_rd;
   logic [7:0]    alu_diff;
   sub_flags_t    alu_flags;
   logic          mem_we;

   sub_decode #(
      .BANK_BITS (BANK_BITS),
      .INDEX_EN  (INDEX_EN),
      .ACCESS_TOP(ACCESS_TOP)
   ) u_decode (
      .instr_i    (instr_i),
      .bank_sel_i (bank_sel_i),
      .ext_mode_i (ext_mode_i),
      .index_ptr_i(index_ptr_i),
      .op_o       (dec_op),
      .to_mem_o   (dec_to_mem),
      .addr_o     (dec_addr),
      .imm_o      (dec_imm)
   );

   sub_alu #(
      .DW(8)
   ) u_alu (
      .minuend_i(min_q),
      .subtra_i (sub_q),
      .diff_o   (alu_diff),
      .flags_o  (alu_flags)
   );

   assign mem_we = (phase_q == PH_WRITE) && (op_q == OP_MEM) && to_mem_q;

   sub_regfile #(
      .BANK_BITS(BANK_BITS)
   ) u_regfile (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (mem_we),
      .waddr_i  (addr_q),
      .wdata_i  (res_q),
      .raddr_a_i(addr_q),
      .rdata_a_o(opnd_rd),
      .raddr_b_i(peek_addr_i),
      .rdata_b_o(peek_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_DECODE;
         op_q     <= OP_NONE;
         to_mem_q <= 1'b0;
         addr_q   <= '0;
         imm_q    <= '0;
         min_q    <= '0;
         sub_q    <= '0;
         res_q    <= '0;
         flg_q    <= '0;
         w_q      <= '0;
         stat_q   <= '0;
         unimpl_q <= 1'b0;
      end else begin
         phase_q  <= phase_q + 2'd1;
         unimpl_q <= 1'b0;
         case (phase_q)
            PH_DECODE: begin
               op_q     <= dec_op;
               to_mem_q <= dec_to_mem;
               addr_q   <= dec_addr;
               imm_q    <= dec_imm;
            end
            PH_READ: begin
               min_q <= (op_q == OP_IMM) ? imm_q : opnd_rd;
               sub_q <= w_q;
            end
            PH_CALC: begin
               res_q <= alu_diff;
               flg_q <= alu_flags;
            end
            default: begin
               if (op_q == OP_NONE) begin
                  unimpl_q <= 1'b1;
               end else begin
                  stat_q <= flg_q;
                  if (!to_mem_q)
                     w_q <= res_q;
               end
            end
         endcase
      end
   end

   assign w_o      = w_q;
   assign status_o = stat_q;
   assign phase_o  = phase_q;
   assign unimpl_o = unimpl_q;

   a_r10_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_q == $past(phase_q) + 2'd1)
      else $error("R10: phase did not advance by one");

   a_r10_w_moves_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_WRITE) |=> $stable(w_q))
      else $error("R10: W changed outside the write phase");

   a_r10_status_moves_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_WRITE) |=> $stable(stat_q))
      else $error("R10: flags changed outside the write phase");

   a_r11_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_q |=> !unimpl_q)
      else $error("R11: strobe held longer than one cycle");

   a_r11_strobe_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      unimpl_q |-> ($stable(w_q) && $stable(stat_q)))
      else $error("R11: state changed by an unimplemented word");

   a_r2_store_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(w_q))
      else $error("R2: memory destination also changed W");

endmodule

// File: tb/sub_exec_unit_bench.sv
module sub_exec_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic [3:0]  bank_sel = 4'd0;
   logic        ext_mode = 1'b0;
   logic [11:0] index_ptr = 12'd0;
   logic [11:0] peek_addr = 12'd0;
   logic [7:0]  peek_data;
   logic [7:0]  w_out;
   logic [4:0]  status;
   logic [1:0]  phase;
   logic        unimpl;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int mw   = 0;
   int mst  = 0;
   int mm [4096];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sub_exec_unit u_sub_exec_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .instr_i    (instr),
      .bank_sel_i (bank_sel),
      .ext_mode_i (ext_mode),
      .index_ptr_i(index_ptr),
      .peek_addr_i(peek_addr),
      .peek_data_o(peek_data),
      .w_o        (w_out),
      .status_o   (status),
      .phase_o    (phase),
      .unimpl_o   (unimpl)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic void model_sub(input int m, input int s, output int r, output int fl);
      int sm, ss, sr, c, dc, z, n, ov;
      r  = (m - s + 256) % 256;
      c  = (m >= s) ? 1 : 0;
      dc = ((m % 16) >= (s % 16)) ? 1 : 0;
      z  = (r == 0) ? 1 : 0;
      n  = (r >= 128) ? 1 : 0;
      sm = (m > 127) ? m - 256 : m;
      ss = (s > 127) ? s - 256 : s;
      sr = sm - ss;
      ov = (sr > 127 || sr < -128) ? 1 : 0;
      fl = n * 16 + ov * 8 + z * 4 + dc * 2 + c;
   endfunction

   function automatic int ea_of(input int a, input int f, input int bank,
                                input int ext, input int ptr);
      if (a != 0) return bank * 256 + f;
      if (ext != 0 && f <= 95) return (ptr + f) % 4096;
      if (f <= 95) return f;
      return 3840 + f;
   endfunction

   task automatic chk_flags(input int act, input int exp);
      chk("R6 carry",     (act >> 0) & 1, (exp >> 0) & 1);
      chk("R8 digit",     (act >> 1) & 1, (exp >> 1) & 1);
      chk("R7 zero",      (act >> 2) & 1, (exp >> 2) & 1);
      chk("R9 overflow",  (act >> 3) & 1, (exp >> 3) & 1);
      chk("R7 negative",  (act >> 4) & 1, (exp >> 4) & 1);
   endtask

   task automatic exec(input logic [15:0] iw, input int exp_unimpl);
      while (phase != 2'd0) @(negedge clk);
      instr = iw;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R11 strobe", int'(unimpl), exp_unimpl);
   endtask

   task automatic peek_chk(input string req, input int ea);
      peek_addr = 12'(ea);
      #1;
      chk(req, int'(peek_data), mm[ea]);
   endtask

   task automatic lit(input int k);
      int r, fl;
      model_sub(k, mw, r, fl);
      exec({8'h08, 8'(k)}, 0);
      chk("R1 W", int'(w_out), r);
      chk_flags(int'(status), fl);
      mw  = r;
      mst = fl;
   endtask

   task automatic set_w(input int v);
      lit((v + mw) % 256);
   endtask

   task automatic regop(input int d, input int a, input int f, input int ea, input string req);
      int r, fl;
      model_sub(mm[ea], mw, r, fl);
      exec({6'b010111, 1'(d), 1'(a), 8'(f)}, 0);
      if (d != 0) mm[ea] = r;
      else        mw = r;
      mst = fl;
      peek_chk(req, ea);
      chk("R2 W", int'(w_out), mw);
      chk_flags(int'(status), fl);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mm[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset values
      chk("R12 W", int'(w_out), 0);
      chk("R12 status", int'(status), 0);
      chk("R12 phase", int'(phase), 0);
      chk("R12 strobe", int'(unimpl), 0);
      peek_chk("R12 mem", 12'h000);
      peek_chk("R12 mem", 12'hABC);
      peek_chk("R12 mem", 12'hFFF);
      rst_n = 1'b1;

      // R10 phase sequence
      for (int i = 0; i < 8; i++) begin
         chk("R10 phase", int'(phase), i % 4);
         @(negedge clk);
      end

      // R10 result not visible before the fourth edge
      while (phase != 2'd0) @(negedge clk);
      instr = 16'h0842;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 early W", int'(w_out), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R10 due W", int'(w_out), 8'h42);
      mw = 8'h42;
      mst = 2 + 1;

      // worked cases: 2-1, 2-2, 2-3
      set_w(1); lit(2);
      chk("R6 2-1 carry", int'(status[0]), 1);
      set_w(2); lit(2);
      chk("R7 2-2 zero", int'(status[2]), 1);
      set_w(3); lit(2);
      chk("R1 2-3 W", int'(w_out), 8'hFF);
      chk("R7 2-3 neg", int'(status[4]), 1);

      // R1 R6 R7 R8 R9 immediate sweep
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 16; j++) begin
            set_w(j * 17);
            lit(a);
         end
      end

      // R3 R4 R5 addressing sweep with memory destination
      set_w(8'h35);
      bank_sel  = 4'd7;
      index_ptr = 12'hFE0;
      for (int ext = 0; ext < 2; ext++) begin
         for (int a = 0; a < 2; a++) begin
            for (int f = 0; f < 256; f++) begin
               string req;
               ext_mode = 1'(ext);
               if (a != 0)                    req = "R3 banked";
               else if (ext != 0 && f <= 95)  req = "R5 indexed";
               else                           req = "R4 access";
               regop(1, a, f, ea_of(a, f, 7, ext, 12'hFE0), req);
            end
         end
      end

      // R5 boundary and pointer change, R3 ignores indexed mode
      ext_mode  = 1'b1;
      index_ptr = 12'h123;
      regop(1, 0, 8'h20, 12'h143, "R5 indexed");
      regop(1, 0, 8'h5F, 12'h182, "R5 top offset");
      regop(1, 0, 8'h60, 12'hF60, "R5 above split");
      bank_sel  = 4'd2;
      regop(1, 1, 8'h20, 12'h220, "R3 ext ignored");
      ext_mode  = 1'b0;
      bank_sel  = 4'd9;
      regop(1, 0, 8'h5F, 12'h05F, "R4 low edge");
      regop(1, 0, 8'h60, 12'hF60, "R4 high edge");

      // R2 W destination, memory untouched
      bank_sel = 4'd4;
      for (int f = 0; f < 256; f += 7) begin
         set_w(f ^ 8'h5A);
         regop(0, 1, f, ea_of(1, f, 4, 0, 0), "R2 mem kept");
         regop(1, 1, f, ea_of(1, f, 4, 0, 0), "R2 mem store");
      end

      // R11 unimplemented words
      begin
         logic [15:0] bad_words [6];
         bad_words[0] = 16'h0000;
         bad_words[1] = 16'h0900;
         bad_words[2] = 16'h5B55;
         bad_words[3] = 16'h5055;
         bad_words[4] = 16'hFFFF;
         bad_words[5] = 16'h6055;
         bank_sel = 4'd0;
         for (int i = 0; i < 6; i++) begin
            exec(bad_words[i], 1);
            chk("R11 W", int'(w_out), mw);
            chk("R11 status", int'(status), mst);
            peek_chk("R11 mem", 12'h055);
            peek_chk("R11 mem", 12'hF55);
            @(negedge clk);
            chk("R11 strobe drop", int'(unimpl), 0);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule